// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block chooses which of eight interrupt lines, if any, is offered to the processor. The command decoder and the edge/level capture logic sit outside it. They supply the raw request vector, the mask vector, the vector base and the mode bits. The block holds two pieces of state: the in-service set and the rotation base, which says which line currently has top priority.

Each line is ranked by its distance from the rotation base, counted upward modulo eight. The line at the base has the highest rank. A pending request is presented only if it outranks every level still in service. Two modes change which in-service levels count in that comparison:
- Special-mask mode drops in-service levels that are currently masked.
- Nested mode on a master controller drops the cascade line.

An acknowledge pulse commits the current winner. Normally this marks the winner in service. With automatic end-of-interrupt, no in-service bit is set, and the rotation base can optionally move just past the winner. The command decoder can overwrite the in-service set or the rotation base at any time, for example to carry out an end-of-interrupt command.

Top module: `prio_resolver`

## Requirements
- R1: The winner is the candidate line with the smallest rank, where rank = (line − rotation base) mod 8 and rank 0 is the highest priority.
- R2: The candidate set is req_i AND NOT mask_i. When it is empty, irq_o is 0.
- R3: irq_o is 1 only when the candidate rank is strictly smaller than the rank of the effective in-service set. An empty set has rank 8. A request at the same level as an in-service line is not presented.
- R4: When special_mask_i is 1, in-service bits whose mask bit is set are ignored in the rank comparison.
- R5: When nested_i and master_i are both 1, in-service bit 2 (the cascade line) is ignored in the rank comparison. With master_i at 0, bit 2 counts normally.
- R6: An acknowledge while irq_o is 1 and auto_eoi_i is 0 sets the winner's bit in isr_o on the next clock edge and leaves rot_base_o unchanged.
- R7: An acknowledge while irq_o is 1 and auto_eoi_i is 1 leaves isr_o unchanged. If rot_aeoi_i is also 1, rot_base_o becomes (winner + 1) mod 8; otherwise it stays unchanged.
- R8: While irq_o is 0, line_o is 7 (spurious) and vector_o is the vector base plus 7. An acknowledge in that state changes neither isr_o nor rot_base_o.
- R9: vector_o equals (vec_base_i AND 0xF8) + line_o.
- R10: isr_load_i and base_load_i replace isr_o and rot_base_o on the next edge, and take precedence over an acknowledge in the same cycle.
- R11: A synchronous reset (rst_n low) clears isr_o and rot_base_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Captured interrupt requests |
| mask_i | input | 8 | Line masks, 1 = masked |
| vec_base_i | input | 8 | Vector base; low three bits ignored |
| special_mask_i | input | 1 | Special-mask mode |
| nested_i | input | 1 | Special fully nested mode |
| master_i | input | 1 | This controller is the master |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt |
| rot_aeoi_i | input | 1 | Rotate on automatic end-of-interrupt |
| ack_i | input | 1 | Acknowledge pulse |
| isr_load_i | input | 1 | Overwrite the in-service set |
| isr_val_i | input | 8 | Value for the in-service overwrite |
| base_load_i | input | 1 | Overwrite the rotation base |
| base_val_i | input | 3 | Value for the rotation base overwrite |
| irq_o | output | 1 | Interrupt pending |
| line_o | output | 3 | Winning line, 7 when none |
| vector_o | output | 8 | Interrupt vector |
| isr_o | output | 8 | In-service set |
| rot_base_o | output | 3 | Rotation base |

## Verification
The clocked properties assume that req_i, mask_i and the mode bits stay steady through the cycle in which ack_i is sampled. They also assume that a load in the same cycle as an acknowledge overrides the acknowledge's update. The stimulus changes every input only on the falling clock edge. It raises each acknowledge for exactly one cycle against state that a preceding load has fixed. Cases where load and acknowledge meet are confined to a dedicated check of that precedence.

// File: rtl/prio_pkg.sv
// Shared types for the interrupt resolver.
// Assumes the line count is a power of two.
package prio_pkg;
    localparam int unsigned DEF_LINES = 8;

    typedef struct packed {
        logic special_mask;
        logic nested;
        logic master;
        logic auto_eoi;
        logic rot_aeoi;
    } mode_t;
endpackage

// File: rtl/rot_rank_enc.sv
// Rotating priority encoder. It rotates a line vector so that the line at
// the base sits at position 0, then returns the index of the lowest set
// bit. That index is the rank; N means the vector is empty.
// Assumes N is a power of two and base_i < N.
module rot_rank_enc #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] base_i,
    output logic [IW:0]   rank_o
);
    logic [N-1:0] rot;

    // Rotate so that the base line lands at rank 0.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            rot[i] = vec_i[(i + int'(base_i)) % N];
        end
    end

    // Lowest set bit wins; the result is N when nothing is set.
    always_comb begin
        rank_o = (IW+1)'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) rank_o = (IW+1)'(i);
        end
    end
endmodule

// File: rtl/isr_ctrl.sv
// In-service set and rotation base registers. A load from the command
// decoder has priority; otherwise a committed acknowledge either marks
// the winner in service or, with automatic EOI, optionally rotates.
// Assumes ack_fire_i is high only when a real winner exists.
module isr_ctrl #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_fire_i,
    input  logic [IW-1:0] win_line_i,
    input  logic          auto_eoi_i,
    input  logic          rot_aeoi_i,
    input  logic          isr_load_i,
    input  logic [N-1:0]  isr_val_i,
    input  logic          base_load_i,
    input  logic [IW-1:0] base_val_i,
    output logic [N-1:0]  isr_o,
    output logic [IW-1:0] base_o
);
    // In-service set update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_o <= '0;
        end else if (isr_load_i) begin
            isr_o <= isr_val_i;
        end else if (ack_fire_i && !auto_eoi_i) begin
            isr_o <= isr_o | (N'(1) << win_line_i);
        end
    end

    // Rotation base update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
        end else if (base_load_i) begin
            base_o <= base_val_i;
        end else if (ack_fire_i && auto_eoi_i && rot_aeoi_i) begin
            base_o <= win_line_i + IW'(1);
        end
    end

    p_load_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        isr_load_i |=> isr_o == $past(isr_val_i));
    p_load_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        base_load_i |=> base_o == $past(base_val_i));
endmodule

// File: rtl/prio_resolver.sv
// Top of the rotating-priority interrupt resolver. It ranks the unmasked
// requests and the effective in-service levels against the rotation
// base, presents the winner only if it strictly outranks service, and
// commits it on acknowledge.
// Assumes the mode bits come from an external command decoder.
module prio_resolver
    import prio_pkg::*;
#(
    parameter int N            = DEF_LINES,
    parameter int VEC_W        = 8,
    parameter int CASCADE_LINE = 2,
    localparam int IW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic [N-1:0]     mask_i,
    input  logic [VEC_W-1:0] vec_base_i,
    input  logic             special_mask_i,
    input  logic             nested_i,
    input  logic             master_i,
    input  logic             auto_eoi_i,
    input  logic             rot_aeoi_i,
    input  logic             ack_i,
    input  logic             isr_load_i,
    input  logic [N-1:0]     isr_val_i,
    input  logic             base_load_i,
    input  logic [IW-1:0]    base_val_i,
    output logic             irq_o,
    output logic [IW-1:0]    line_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [N-1:0]     isr_o,
    output logic [IW-1:0]    rot_base_o
);
    mode_t        mode;
    logic [N-1:0] cand;
    logic [N-1:0] isr_eff;
    logic [IW:0]  cand_rank;
    logic [IW:0]  svc_rank;
    logic [IW:0]  line_sum;

    // Gather the mode bits into one record.
    always_comb begin
        mode.special_mask = special_mask_i;
        mode.nested       = nested_i;
        mode.master       = master_i;
        mode.auto_eoi     = auto_eoi_i;
        mode.rot_aeoi     = rot_aeoi_i;
    end

    // Build the candidate set and the in-service set used for comparison.
    always_comb begin
        cand    = req_i & ~mask_i;
        isr_eff = isr_o;
        if (mode.special_mask) isr_eff = isr_eff & ~mask_i;
        if (mode.nested && mode.master) isr_eff[CASCADE_LINE] = 1'b0;
    end

    // One encoder per set, in a generate loop.
    for (genvar g = 0; g < 2; g++) begin : g_rank
        logic [IW:0] r;
        rot_rank_enc #(.N(N)) u_enc (
            .vec_i  (g == 0 ? cand : isr_eff),
            .base_i (rot_base_o),
            .rank_o (r)
        );
    end
    assign cand_rank = g_rank[0].r;
    assign svc_rank  = g_rank[1].r;

    // Compare the two ranks, and map the winning rank back to a line.
    always_comb begin
        irq_o    = cand_rank < svc_rank;
        line_sum = cand_rank + {1'b0, rot_base_o};
        line_o   = irq_o ? line_sum[IW-1:0] : IW'(N - 1);
        vector_o = {vec_base_i[VEC_W-1:IW], {IW{1'b0}}} + VEC_W'(line_o);
    end

    isr_ctrl #(.N(N)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_fire_i  (ack_i && irq_o),
        .win_line_i  (line_o),
        .auto_eoi_i  (mode.auto_eoi),
        .rot_aeoi_i  (mode.rot_aeoi),
        .isr_load_i  (isr_load_i),
        .isr_val_i   (isr_val_i),
        .base_load_i (base_load_i),
        .base_val_i  (base_val_i),
        .isr_o       (isr_o),
        .base_o      (rot_base_o)
    );

    p_pend_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i[line_o] && !mask_i[line_o]));
    p_winner_not_in_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !isr_eff[line_o]);
    p_spurious_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> line_o == IW'(N - 1));
    p_spurious_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !isr_load_i && !base_load_i)
        |=> (isr_o == $past(isr_o) && rot_base_o == $past(rot_base_o)));
    p_ack_marks_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !auto_eoi_i && !isr_load_i) |=> isr_o[$past(line_o)]);
    p_aeoi_keeps_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && auto_eoi_i && !isr_load_i) |=> isr_o == $past(isr_o));
    p_aeoi_rotates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && auto_eoi_i && rot_aeoi_i && !base_load_i)
        |=> rot_base_o == IW'($past(line_o) + 1'b1));
endmodule

// File: tb/prio_resolver_test.sv
module prio_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i, mask_i, vec_base_i, isr_val_i;
    logic       special_mask_i, nested_i, master_i, auto_eoi_i, rot_aeoi_i;
    logic       ack_i, isr_load_i, base_load_i;
    logic [2:0] base_val_i;
    logic       irq_o;
    logic [2:0] line_o, rot_base_o;
    logic [7:0] vector_o, isr_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
        .vec_base_i(vec_base_i), .special_mask_i(special_mask_i),
        .nested_i(nested_i), .master_i(master_i), .auto_eoi_i(auto_eoi_i),
        .rot_aeoi_i(rot_aeoi_i), .ack_i(ack_i), .isr_load_i(isr_load_i),
        .isr_val_i(isr_val_i), .base_load_i(base_load_i),
        .base_val_i(base_val_i), .irq_o(irq_o), .line_o(line_o),
        .vector_o(vector_o), .isr_o(isr_o), .rot_base_o(rot_base_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rank_of(input logic [7:0] v, input int b);
        for (int r = 0; r < 8; r++) if (v[(r + b) % 8]) return r;
        return 8;
    endfunction

    function automatic void model(input logic [7:0] req, input logic [7:0] msk,
                                  input logic [7:0] isr, input int b,
                                  input bit smm, input bit nst, input bit mst,
                                  output bit pend, output int line);
        logic [7:0] ie;
        int rc, ri;
        ie = isr;
        if (smm) ie = ie & ~msk;
        if (nst && mst) ie[2] = 1'b0;
        rc = rank_of(req & ~msk, b);
        ri = rank_of(ie, b);
        pend = rc < ri;
        line = pend ? (rc + b) % 8 : 7;
    endfunction

    // Load state and drive the inputs at a falling edge; sample after the next rise.
    task automatic set_case(input logic [7:0] req, input logic [7:0] msk,
                            input logic [7:0] isr, input int b, input logic [7:0] vb,
                            input bit smm, input bit nst, input bit mst);
        @(negedge clk);
        req_i = req; mask_i = msk; vec_base_i = vb;
        special_mask_i = smm; nested_i = nst; master_i = mst;
        isr_load_i = 1'b1; isr_val_i = isr;
        base_load_i = 1'b1; base_val_i = 3'(b);
        ack_i = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic do_ack(input bit ae, input bit ra);
        @(negedge clk);
        isr_load_i = 1'b0; base_load_i = 1'b0;
        auto_eoi_i = ae; rot_aeoi_i = ra; ack_i = 1'b1;
        @(posedge clk); #2;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] masks [4];
        logic [7:0] isrs [4];
        bit pend;
        int line;
        masks = '{8'h00, 8'hA5, 8'h3C, 8'h81};
        isrs  = '{8'h00, 8'h04, 8'h20, 8'h81};

        rst_n = 1'b0; req_i = '0; mask_i = '0; vec_base_i = 8'h40; isr_val_i = '0;
        special_mask_i = 0; nested_i = 0; master_i = 0; auto_eoi_i = 0;
        rot_aeoi_i = 0; ack_i = 0; isr_load_i = 0; base_load_i = 0; base_val_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R11 isr after reset", isr_o, 0);
        chk("R11 base after reset", rot_base_o, 0);
        chk("R11 irq after reset", irq_o, 0);

        // R2: a masked-only request is not presented.
        set_case(8'h08, 8'h08, 8'h00, 0, 8'h20, 0, 0, 0);
        chk("R2 masked request", irq_o, 0);
        // R4: special mask hides the masked in-service level.
        set_case(8'h04, 8'h01, 8'h01, 0, 8'h20, 1, 0, 0);
        chk("R4 smm irq", irq_o, 1);
        chk("R4 smm line", line_o, 2);
        set_case(8'h04, 8'h01, 8'h01, 0, 8'h20, 0, 0, 0);
        chk("R4 no smm blocked", irq_o, 0);
        // R5: nested master ignores cascade in service.
        set_case(8'h08, 8'h00, 8'h04, 0, 8'h20, 0, 1, 1);
        chk("R5 nested master irq", irq_o, 1);
        chk("R5 nested master line", line_o, 3);
        set_case(8'h08, 8'h00, 8'h04, 0, 8'h20, 0, 1, 0);
        chk("R5 nested slave blocked", irq_o, 0);
        // R3: same level as in service is not presented.
        set_case(8'h10, 8'h00, 8'h10, 3, 8'h20, 0, 0, 0);
        chk("R3 equal level", irq_o, 0);
        // R8: spurious path and ack with no winner.
        set_case(8'h00, 8'h00, 8'h12, 5, 8'h6B, 0, 0, 0);
        chk("R8 spurious line", line_o, 7);
        chk("R8 spurious vector", vector_o, 8'h6F);
        do_ack(0, 0);
        chk("R8 spurious ack isr", isr_o, 8'h12);
        chk("R8 spurious ack base", rot_base_o, 5);
        // R10: a load beats an acknowledge in the same cycle.
        set_case(8'h10, 8'h00, 8'h00, 0, 8'h20, 0, 0, 0);
        @(negedge clk);
        isr_val_i = 8'h02; base_val_i = 3'd6; auto_eoi_i = 0; rot_aeoi_i = 0; ack_i = 1;
        @(posedge clk); #2;
        chk("R10 isr load wins", isr_o, 8'h02);
        set_case(8'h10, 8'h00, 8'h00, 0, 8'h20, 0, 0, 0);
        @(negedge clk);
        base_val_i = 3'd6; auto_eoi_i = 1; rot_aeoi_i = 1; ack_i = 1;
        @(posedge clk); #2;
        chk("R10 base load wins", rot_base_o, 6);
        @(negedge clk); ack_i = 0; auto_eoi_i = 0; rot_aeoi_i = 0;

        // Sweep the presentation logic: R1, R3, R9.
        for (int b = 0; b < 8; b++) begin
            for (int m = 0; m < 8; m++) begin
                for (int r = 0; r < 256; r++) begin
                    logic [7:0] rq, mk, is, vb;
                    rq = 8'(r);
                    mk = masks[(r ^ b) & 3];
                    is = isrs[((r >> 2) ^ m) & 3];
                    vb = rq ^ 8'h5B;
                    set_case(rq, mk, is, b, vb, m[0], m[1], m[2]);
                    model(rq, mk, is, b, m[0], m[1], m[2], pend, line);
                    chk("R3 irq", irq_o, int'(pend));
                    chk("R1 line", line_o, line);
                    chk("R9 vector", vector_o, int'(vb & 8'hF8) + line);
                end
            end
        end

        // Sweep acknowledge commits: R6, R7.
        for (int b = 0; b < 8; b++) begin
            for (int c = 0; c < 3; c++) begin
                for (int r = 0; r < 256; r++) begin
                    logic [7:0] rq, mk, is, exp_isr;
                    int exp_base;
                    bit ae, ra;
                    ae = (c != 0); ra = (c == 2);
                    rq = 8'(r);
                    mk = masks[(r >> 2) & 3];
                    is = isrs[r & 3];
                    set_case(rq, mk, is, b, 8'h00, 0, 0, 0);
                    model(rq, mk, is, b, 0, 0, 0, pend, line);
                    exp_isr = is;
                    exp_base = b;
                    if (pend && !ae) exp_isr[line] = 1'b1;
                    if (pend && ae && ra) exp_base = (line + 1) % 8;
                    do_ack(ae, ra);
                    chk(ae ? "R7 isr after ack" : "R6 isr after ack", isr_o, exp_isr);
                    chk(ae ? "R7 base after ack" : "R6 base after ack", rot_base_o, exp_base);
                end
            end
        end

        // R11: reset clears loaded state.
        set_case(8'h00, 8'h00, 8'hFF, 4, 8'h00, 0, 0, 0);
        @(negedge clk); isr_load_i = 0; base_load_i = 0; rst_n = 0;
        @(posedge clk); #2;
        chk("R11 isr cleared", isr_o, 0);
        chk("R11 base cleared", rot_base_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule